// File: doc/BRIEF.md
# SONET Link Alarm and Statistics Monitor

This block sits beside a SONET/SDH framer and turns its raw status lines and per-frame event strobes into what a host polls: a word of sticky alarm bits and a set of saturating per-interval counters. A one-millisecond tick drives a persistence timer that derives loss-of-frame from the out-of-frame line. The timer raises loss-of-frame only after out-of-frame has been held continuously for longer than the configured number of milliseconds. It drops loss-of-frame only after out-of-frame has been absent for the same span.

The host pulses a single read strobe. In that one cycle every counter and every alarm bit is copied into a snapshot bank and the live copies restart from zero. An event or a condition present in the strobe cycle itself lands in the snapshot, so nothing is lost or counted twice. The host then walks a select input across the snapshot bank and reads each word on a combinational data output. A mode input picks packet-over-SONET or cell (ATM) counting. Event strobes that belong to the other mode are dropped. Control and status pins are plain levels, and no stream handshake exists because the host never applies back-pressure.

Top module: `link_stat_mon`

## Requirements
- R1: Loss-of-frame (`lof`) goes high in the cycle after the (LOF_MS+1)-th `ms_tick` seen with `st_oof` high and `lof` low. Any cycle with `st_oof` low before that point restarts the count.
- R2: Once high, `lof` goes low in the cycle after the (LOF_MS+1)-th `ms_tick` seen with `st_oof` low. Any cycle with `st_oof` high before that point restarts the count.
- R3: Select 0 returns the alarm word. Bit 0 is signal loss, bit 1 out-of-frame, bit 2 loss-of-frame, bit 3 line AIS, bit 4 line RDI, bit 5 clock loss, bit 6 reference loss and bit 7 pointer loss. A bit reads 1 when its condition was high in any cycle after the previous strobe, up to and including the current strobe cycle.
- R4: A `rd_stb` cycle copies every counter into the snapshot, including that cycle's events, and restarts the live counters from zero. The next snapshot holds only later events.
- R5: Select k (1..12) returns the snapshot counter in this order: 1 path BIP, 2 path REI, 3 frames, 4 payload bytes, 5 FCS fail, 6 aborts, 7 short, 8 long, 9 FIFO drops, 10 cells, 11 idle cells, 12 HEC fails. Other selects return 0.
- R6: In packet mode (`atm_mode`=0), each `ev_frame` adds 1 to frames and adds `ev_len` to payload bytes.
- R7: In packet mode, an `ev_frame` with `ev_len` < `min_len` adds 1 to short, and one with `ev_len` > `max_len` adds 1 to long.
- R8: In packet mode, `ev_fcs`, `ev_abort` and `ev_drop` each add 1 to their own counter.
- R9: In cell mode (`atm_mode`=1), `ev_cell`, `ev_idle` and `ev_hec` each add 1 to their own counter.
- R10: Packet events are ignored in cell mode and cell events in packet mode. Path BIP and REI count in both modes.
- R11: Every counter stops at 2^CNT_W-1 and never wraps.
- R12: After reset, `lof` is 0 and every snapshot word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| atm_mode | input | 1 | 0 packet counting, 1 cell counting |
| min_len | input | LEN_W | Short-frame threshold |
| max_len | input | LEN_W | Long-frame threshold |
| st_los | input | 1 | Signal loss level |
| st_oof | input | 1 | Out-of-frame level |
| st_lais | input | 1 | Line AIS level |
| st_lrdi | input | 1 | Line RDI level |
| st_loc | input | 1 | Clock recovery loss level |
| st_lor | input | 1 | Reference loss level |
| st_lop | input | 1 | Path pointer loss level |
| ev_bip | input | 1 | Path BIP error strobe |
| ev_rei | input | 1 | Path REI strobe |
| ev_frame | input | 1 | Good frame strobe |
| ev_fcs | input | 1 | FCS failure strobe |
| ev_abort | input | 1 | Aborted frame strobe |
| ev_drop | input | 1 | FIFO drop strobe |
| ev_cell | input | 1 | Non-idle cell strobe |
| ev_idle | input | 1 | Idle cell strobe |
| ev_hec | input | 1 | Header checksum failure strobe |
| ev_len | input | LEN_W | Byte count of the frame on `ev_frame` |
| rd_stb | input | 1 | Snapshot-and-clear strobe |
| rd_sel | input | 4 | Snapshot word select |
| rd_data | output | CNT_W | Selected snapshot word |
| lof | output | 1 | Live loss-of-frame state |

## Verification
The bound checker watches on every clock that `lof` changes only on a tick and only in the direction the sampled out-of-frame level calls for. It also checks that each live counter reads zero right after a strobe and never falls between strobes. A frozen frame counter in cell mode and the capture of a line AIS pulse at the strobe are checked the same way. Exact counts, the short/long split against thresholds, the restart of the persistence timer after a glitch, the saturation value and the select map can only be shown by the bench's scenarios. There a behavioural model is compared with the read port and `lof` after every clock.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int NUM_CNT = 12;
  localparam int NUM_ALM = 8;

  // Counter slots; select value on the read port is slot + 1.
  typedef enum int {
    C_BIP   = 0,
    C_REI   = 1,
    C_FRM   = 2,
    C_BYTE  = 3,
    C_FCS   = 4,
    C_ABRT  = 5,
    C_SHORT = 6,
    C_LONG  = 7,
    C_DROP  = 8,
    C_CELL  = 9,
    C_IDLE  = 10,
    C_HEC   = 11
  } cnt_slot_e;
endpackage

// File: rtl/lsm_lof_timer.sv
module lsm_lof_timer #(
  parameter int LOF_MS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic oof,
  output logic lof
);
  localparam int TW = $clog2(LOF_MS + 1) + 1;

  logic [TW-1:0] tcnt;

  // Counts ticks while the input disagrees with the held state; any
  // agreeing cycle restarts the count, so only unbroken spans switch it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lof  <= 1'b0;
      tcnt <= '0;
    end else if (oof == lof) begin
      tcnt <= '0;
    end else if (ms_tick) begin
      if (tcnt == TW'(LOF_MS)) begin
        lof  <= ~lof;
        tcnt <= '0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsm_sat_counter.sv
module lsm_sat_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] snap
);
  localparam int SW = CNT_W + 1;

  logic [SW-1:0]    sum;
  logic [CNT_W-1:0] nxt;

  assign sum = {1'b0, cnt} + SW'(inc);
  assign nxt = sum[CNT_W] ? '1 : sum[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      snap <= '0;
    end else if (clr) begin
      snap <= nxt;
      cnt  <= '0;
    end else begin
      cnt  <= nxt;
    end
  end
endmodule

// File: rtl/lsm_sticky_bank.sv
module lsm_sticky_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] cond,
  output logic [N-1:0] snap
);
  logic [N-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      snap <= '0;
    end else if (clr) begin
      snap <= held | cond;
      held <= '0;
    end else begin
      held <= held | cond;
    end
  end
endmodule

// File: rtl/link_stat_mon.sv
module link_stat_mon
  import lsm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16,
  parameter int LOF_MS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             atm_mode,
  input  logic [LEN_W-1:0] min_len,
  input  logic [LEN_W-1:0] max_len,
  input  logic             st_los,
  input  logic             st_oof,
  input  logic             st_lais,
  input  logic             st_lrdi,
  input  logic             st_loc,
  input  logic             st_lor,
  input  logic             st_lop,
  input  logic             ev_bip,
  input  logic             ev_rei,
  input  logic             ev_frame,
  input  logic             ev_fcs,
  input  logic             ev_abort,
  input  logic             ev_drop,
  input  logic             ev_cell,
  input  logic             ev_idle,
  input  logic             ev_hec,
  input  logic [LEN_W-1:0] ev_len,
  input  logic             rd_stb,
  input  logic [3:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             lof
);
  logic [NUM_CNT-1:0][LEN_W-1:0] inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_CNT-1:0][CNT_W-1:0] snap_q;
  logic [NUM_ALM-1:0]            alm_now;
  logic [NUM_ALM-1:0]            alm_snap;
  logic                          pkt;
  logic                          frm;

  lsm_lof_timer #(.LOF_MS(LOF_MS)) u_lof (
    .clk     (clk),
    .rst_n   (rst_n),
    .ms_tick (ms_tick),
    .oof     (st_oof),
    .lof     (lof)
  );

  assign pkt = ~atm_mode;
  assign frm = pkt & ev_frame;

  always_comb begin
    inc          = '0;
    inc[C_BIP]   = LEN_W'(ev_bip);
    inc[C_REI]   = LEN_W'(ev_rei);
    inc[C_FRM]   = LEN_W'(frm);
    inc[C_BYTE]  = frm ? ev_len : '0;
    inc[C_FCS]   = LEN_W'(pkt & ev_fcs);
    inc[C_ABRT]  = LEN_W'(pkt & ev_abort);
    inc[C_SHORT] = LEN_W'(frm & (ev_len < min_len));
    inc[C_LONG]  = LEN_W'(frm & (ev_len > max_len));
    inc[C_DROP]  = LEN_W'(pkt & ev_drop);
    inc[C_CELL]  = LEN_W'(atm_mode & ev_cell);
    inc[C_IDLE]  = LEN_W'(atm_mode & ev_idle);
    inc[C_HEC]   = LEN_W'(atm_mode & ev_hec);
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    lsm_sat_counter #(.CNT_W(CNT_W), .INC_W(LEN_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rd_stb),
      .inc   (inc[g]),
      .cnt   (cnt_q[g]),
      .snap  (snap_q[g])
    );
  end

  assign alm_now = {st_lop, st_lor, st_loc, st_lrdi, st_lais, lof, st_oof, st_los};

  lsm_sticky_bank #(.N(NUM_ALM)) u_alm (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rd_stb),
    .cond  (alm_now),
    .snap  (alm_snap)
  );

  always_comb begin
    rd_data = '0;
    if (rd_sel == 4'd0) rd_data = CNT_W'(alm_snap);
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rd_sel == 4'(i + 1)) rd_data = snap_q[i];
    end
  end
endmodule

// File: rtl/lsm_checker.sv
module lsm_checker
  import lsm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LOF_MS = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ms_tick,
  input logic                          st_oof,
  input logic                          st_lais,
  input logic                          lof,
  input logic                          rd_stb,
  input logic                          atm_mode,
  input logic [NUM_ALM-1:0]            alm_snap,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q
);
  a_r1_lof_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof) |-> ($past(st_oof) && $past(ms_tick)));

  a_r2_lof_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lof) |-> (!$past(st_oof) && $past(ms_tick)));

  a_r1_lof_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> $stable(lof));

  a_r3_lais_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && st_lais) |=> alm_snap[3]);

  a_r10_frames_frozen_in_cell_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (atm_mode && !rd_stb) |=> $stable(cnt_q[C_FRM]));

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
    a_r4_live_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> (cnt_q[g] == '0));

    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> (cnt_q[g] >= $past(cnt_q[g])));
  end
endmodule

bind link_stat_mon lsm_checker #(.CNT_W(CNT_W), .LOF_MS(LOF_MS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ms_tick  (ms_tick),
  .st_oof   (st_oof),
  .st_lais  (st_lais),
  .lof      (lof),
  .rd_stb   (rd_stb),
  .atm_mode (atm_mode),
  .alm_snap (alm_snap),
  .cnt_q    (cnt_q)
);

// File: tb/sim_link_stat_mon.sv
`timescale 1ns/1ps
module sim_link_stat_mon;
  localparam int CW  = 16;
  localparam int LW  = 16;
  localparam int LMS = 3;
  localparam longint CMAX = (64'd1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 0, atm_mode = 0;
  logic [LW-1:0] min_len = 16'd64, max_len = 16'd1500, ev_len = '0;
  logic st_los = 0, st_oof = 0, st_lais = 0, st_lrdi = 0, st_loc = 0, st_lor = 0, st_lop = 0;
  logic ev_bip = 0, ev_rei = 0, ev_frame = 0, ev_fcs = 0, ev_abort = 0, ev_drop = 0;
  logic ev_cell = 0, ev_idle = 0, ev_hec = 0;
  logic rd_stb = 0;
  logic [3:0] rd_sel = '0;
  logic [CW-1:0] rd_data;
  logic lof;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  link_stat_mon #(.CNT_W(CW), .LEN_W(LW), .LOF_MS(LMS)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .atm_mode(atm_mode),
    .min_len(min_len), .max_len(max_len),
    .st_los(st_los), .st_oof(st_oof), .st_lais(st_lais), .st_lrdi(st_lrdi),
    .st_loc(st_loc), .st_lor(st_lor), .st_lop(st_lop),
    .ev_bip(ev_bip), .ev_rei(ev_rei), .ev_frame(ev_frame), .ev_fcs(ev_fcs),
    .ev_abort(ev_abort), .ev_drop(ev_drop), .ev_cell(ev_cell), .ev_idle(ev_idle),
    .ev_hec(ev_hec), .ev_len(ev_len), .rd_stb(rd_stb), .rd_sel(rd_sel),
    .rd_data(rd_data), .lof(lof)
  );

  // Behavioural reference model
  longint m_live[12];
  longint m_snap[12];
  int     m_held, m_alm, m_lof, m_t;

  function automatic longint sat(longint v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic longint model_rd(int sel);
    if (sel == 0) return longint'(m_alm);
    if (sel >= 1 && sel <= 12) return m_snap[sel-1];
    return 0;
  endfunction

  always @(posedge clk) begin
    longint add[12];
    int now;
    if (!rst_n) begin
      foreach (m_live[i]) begin m_live[i] = 0; m_snap[i] = 0; end
      m_held = 0; m_alm = 0; m_lof = 0; m_t = 0;
    end else begin
      foreach (add[i]) add[i] = 0;
      add[0] = ev_bip; add[1] = ev_rei;
      if (!atm_mode) begin
        if (ev_frame) begin
          add[2] = 1; add[3] = ev_len;
          if (ev_len < min_len) add[6] = 1;
          if (ev_len > max_len) add[7] = 1;
        end
        add[4] = ev_fcs; add[5] = ev_abort; add[8] = ev_drop;
      end else begin
        add[9] = ev_cell; add[10] = ev_idle; add[11] = ev_hec;
      end
      now = st_los | (st_oof << 1) | (m_lof << 2) | (st_lais << 3) | (st_lrdi << 4)
          | (st_loc << 5) | (st_lor << 6) | (st_lop << 7);
      if (rd_stb) begin
        foreach (m_live[i]) begin m_snap[i] = sat(m_live[i] + add[i]); m_live[i] = 0; end
        m_alm = m_held | now; m_held = 0;
      end else begin
        foreach (m_live[i]) m_live[i] = sat(m_live[i] + add[i]);
        m_held = m_held | now;
      end
      if (int'(st_oof) == m_lof) m_t = 0;
      else if (ms_tick) begin
        if (m_t == LMS) begin m_lof = 1 - m_lof; m_t = 0; end
        else m_t = m_t + 1;
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock, then compare against the model mid-cycle.
  task automatic cyc();
    @(posedge clk);
    #5;
    chk("R1 R2 lof vs model", longint'(lof), longint'(m_lof));
    chk("R5 read port vs model", longint'(rd_data), model_rd(int'(rd_sel)));
  endtask

  task automatic snapshot();
    rd_stb = 1; cyc(); rd_stb = 0;
  endtask

  task automatic peek(int sel, longint exp, string tag);
    rd_sel = 4'(sel);
    #1;
    chk(tag, longint'(rd_data), exp);
  endtask

  task automatic frame(int len);
    ev_frame = 1; ev_len = 16'(len); cyc(); ev_frame = 0; ev_len = '0;
  endtask

  task automatic tick_group();
    ms_tick = 1; cyc(); ms_tick = 0;
    repeat (3) cyc();
  endtask

  initial begin : watchdog
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #5;
    // R12 reset state
    chk("R12 lof after reset", longint'(lof), 0);
    peek(0, 0, "R12 alarm word after reset");
    peek(4, 0, "R12 byte snapshot after reset");
    rst_n = 1;
    cyc();

    // R6 R7 packet frames: 40 short, 100 normal, 2000 long
    frame(40); frame(100); frame(2000);
    cyc();
    snapshot();
    peek(3, 3, "R6 frames");
    peek(4, 2140, "R6 payload bytes");
    peek(7, 1, "R7 short frames");
    peek(8, 1, "R7 long frames");
    peek(13, 0, "R5 unused select");

    // R4 event in strobe cycle lands in the snapshot
    ev_frame = 1; ev_len = 16'd10; rd_stb = 1; cyc();
    ev_frame = 0; ev_len = '0; rd_stb = 0;
    peek(3, 1, "R4 frame on strobe cycle");
    peek(7, 1, "R4 short on strobe cycle");
    cyc();
    snapshot();
    peek(3, 0, "R4 no double count");

    // R8 packet error counters
    ev_fcs = 1; cyc(); cyc(); ev_fcs = 0;
    ev_abort = 1; cyc(); ev_abort = 0;
    ev_drop = 1; repeat (3) cyc(); ev_drop = 0;
    snapshot();
    peek(5, 2, "R8 fcs");
    peek(6, 1, "R8 abort");
    peek(9, 3, "R8 drop");

    // R10 cell events ignored in packet mode, BIP counted
    ev_cell = 1; ev_idle = 1; ev_hec = 1; ev_bip = 1; cyc();
    ev_cell = 0; ev_idle = 0; ev_hec = 0; ev_bip = 0;
    snapshot();
    peek(10, 0, "R10 cells ignored in packet mode");
    peek(12, 0, "R10 hec ignored in packet mode");
    peek(1, 1, "R10 bip counted in packet mode");

    // R9 R10 cell mode
    atm_mode = 1;
    ev_cell = 1; cyc(); cyc(); ev_cell = 0;
    ev_idle = 1; ev_hec = 1; ev_rei = 1; cyc();
    ev_idle = 0; ev_hec = 0; ev_rei = 0;
    frame(200); ev_fcs = 1; cyc(); ev_fcs = 0;
    snapshot();
    peek(10, 2, "R9 cells");
    peek(11, 1, "R9 idle cells");
    peek(12, 1, "R9 hec");
    peek(3, 0, "R10 frames ignored in cell mode");
    peek(5, 0, "R10 fcs ignored in cell mode");
    peek(2, 1, "R10 rei counted in cell mode");
    atm_mode = 0;

    // R3 sticky alarm
    st_lais = 1; cyc(); st_lais = 0;
    repeat (4) cyc();
    snapshot();
    peek(0, 8, "R3 line AIS sticky");
    st_lop = 1; rd_stb = 1; cyc(); rd_stb = 0; st_lop = 0;
    peek(0, 128, "R3 pointer loss on strobe cycle, AIS cleared");

    // R1 with restart, then R2
    st_oof = 1;
    tick_group(); tick_group();
    st_oof = 0; cyc(); st_oof = 1;
    repeat (3) tick_group();
    chk("R1 lof low after restart and three ticks", longint'(lof), 0);
    ms_tick = 1; cyc(); ms_tick = 0;
    chk("R1 lof high on fourth tick", longint'(lof), 1);
    st_oof = 0;
    repeat (3) tick_group();
    chk("R2 lof still high after three ticks", longint'(lof), 1);
    ms_tick = 1; cyc(); ms_tick = 0;
    chk("R2 lof low on fourth tick", longint'(lof), 0);
    snapshot();
    peek(0, 6, "R3 oof and lof alarm bits");

    // R11 saturation
    frame(40000); frame(40000); frame(40000);
    snapshot();
    peek(4, CMAX, "R11 byte counter saturates");
    peek(8, 3, "R11 long counter unaffected");

    repeat (3) cyc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule